// File: doc/BRIEF.md
# Burst Frame Writer

This block carries finished 32-bit pixels from a local pixel FIFO into external memory. It talks to the memory controller through a plain request/acknowledge port: it first pushes a fixed-length burst of words into the controller's write buffer, then presents a write address and holds the request until the controller accepts it. Each word holds one pixel, and every transfer is a burst of eight words.

Recording is gated twice. The block waits until both the image sensor and the memory controller report that their initialization is complete. It then waits for a fresh rising edge of vertical sync, so that the first burst lines up with the start of a frame. After that it runs without stopping. It starts a burst whenever the FIFO's programmable-empty flag shows that a whole burst is available. The address steps by one burst of bytes each time and returns to zero after exactly one frame of 640 by 480 pixels at 4 bytes each (1,228,800 bytes, 38,400 bursts). A one-cycle pulse marks each wrap. The frame size, burst length, word width, address width and FIFO read latency are all parameters.

Top module: `burst_frame_writer`

## Requirements
- R1: Until both init-done inputs have been seen high and a later rising edge of vsync has been sampled, `recording_o` is low and no FIFO read or address request occurs. `recording_o` rises on the clock edge that samples the first vsync rise after both init-done inputs have been high for at least one earlier cycle, and it then stays high until reset.
- R2: A vsync rise that happens before both init-done inputs are high is ignored. So is vsync being held high while initialization completes. Only a later low-to-high transition starts recording.
- R3: A burst starts only when the FIFO programmable-empty input (high means fewer than BURST_LEN words are stored) is low while the block is idle. While it stays high, no read takes place.
- R4: A burst reads exactly BURST_LEN (default 8) words on consecutive cycles. With FIFO_LAT=1, each word is pushed to the write buffer one cycle after its read strobe, on `wr_data_o` unchanged, and in FIFO order.
- R5: The address request rises in the cycle after the last of the burst's BURST_LEN pushes, and never before all of them.
- R6: Once raised, the address request and its address stay steady until the acknowledge is sampled high. No FIFO read or push happens while a request is pending.
- R7: The address starts at zero. In the cycle after an accepted request, it has grown by BURST_LEN×WORD_W/8 bytes (32 by default).
- R8: When the grown address would equal the frame size FRAME_W×FRAME_H×WORD_W/8 (1,228,800 by default), the address becomes zero instead, and `frame_done_o` is high for exactly that one cycle. At no other time is it high.
- R9: During and right after reset, the address is zero and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sensor_ready_i | input | 1 | Image sensor initialization complete |
| memctl_ready_i | input | 1 | Memory controller initialization complete |
| vsync_i | input | 1 | Vertical sync, synchronous to clk |
| fifo_prog_empty_i | input | 1 | High when fewer than one burst of words is stored |
| fifo_rd_en_o | output | 1 | Pixel FIFO read strobe |
| fifo_data_i | input | WORD_W | Pixel FIFO read data |
| wr_push_o | output | 1 | Push one word into the controller write buffer |
| wr_data_o | output | WORD_W | Word being pushed |
| addr_req_o | output | 1 | Write address request, held until accepted |
| addr_o | output | ADDR_W | Byte address of the current burst |
| addr_ack_i | input | 1 | Controller accepts the address request |
| recording_o | output | 1 | High once recording has started |
| frame_done_o | output | 1 | One-cycle pulse when the address wraps to zero |

## Verification
The assertions assume that the FIFO keeps its programmable-empty flag honest, so at least one burst of words is stored whenever the flag is low. They also assume that the acknowledge arrives only while a request is pending and never lasts longer than one cycle. The bench models the FIFO from a count of added and read words, derives the flag from that count, and flags any read of an empty model. Its acknowledge responder answers only a visible request, after a delay that cycles from zero to three cycles. A reduced frame of four bursts lets the run cover several wraps together with the start-up gating cases.

// File: rtl/bfw_pkg.sv
package bfw_pkg;

   typedef enum logic [1:0] {
      RUN_WAIT_INIT,
      RUN_WAIT_EDGE,
      RUN_ACTIVE
   } run_state_t;

   typedef enum logic [1:0] {
      BST_IDLE,
      BST_READ,
      BST_DRAIN,
      BST_REQ
   } bst_state_t;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/bfw_run_ctrl.sv
module bfw_run_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic sensor_ready_i,
   input  logic memctl_ready_i,
   input  logic vsync_i,
   output logic active_o
);
   import bfw_pkg::*;

   run_state_t state_q, state_d;
   logic       vsync_q;
   logic       both_ready;
   logic       vsync_rise;

   assign both_ready = sensor_ready_i & memctl_ready_i;
   assign vsync_rise = vsync_i & ~vsync_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         RUN_WAIT_INIT: if (both_ready) state_d = RUN_WAIT_EDGE;
         RUN_WAIT_EDGE: begin
            if (!both_ready)     state_d = RUN_WAIT_INIT;
            else if (vsync_rise) state_d = RUN_ACTIVE;
         end
         RUN_ACTIVE:    state_d = RUN_ACTIVE;
         default:       state_d = RUN_WAIT_INIT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= RUN_WAIT_INIT;
         vsync_q <= 1'b0;
      end else begin
         state_q <= state_d;
         vsync_q <= vsync_i;
      end
   end

   assign active_o = (state_q == RUN_ACTIVE);

endmodule

// File: rtl/bfw_burst_fsm.sv
module bfw_burst_fsm #(
   parameter int unsigned BURST_LEN = 8,
   parameter int unsigned FIFO_LAT  = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active_i,
   input  logic prog_empty_i,
   input  logic ack_i,
   output logic rd_en_o,
   output logic push_o,
   output logic req_o,
   output logic advance_o
);
   import bfw_pkg::*;

   localparam int unsigned CNT_W = cnt_width(BURST_LEN);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BURST_LEN - 1);
   localparam bst_state_t AFTER_READ = (FIFO_LAT == 1) ? BST_DRAIN : BST_REQ;

   bst_state_t       state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      unique case (state_q)
         BST_IDLE: begin
            if (active_i && !prog_empty_i) begin
               state_d = BST_READ;
               cnt_d   = '0;
            end
         end
         BST_READ: begin
            if (cnt_q == LAST_IDX) state_d = AFTER_READ;
            else                   cnt_d   = cnt_q + 1'b1;
         end
         BST_DRAIN: state_d = BST_REQ;
         BST_REQ:   if (ack_i) state_d = BST_IDLE;
         default:   state_d = BST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= BST_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign rd_en_o   = (state_q == BST_READ);
   assign req_o     = (state_q == BST_REQ);
   assign advance_o = req_o & ack_i;

   generate
      if (FIFO_LAT == 0) begin : g_fwft
         assign push_o = rd_en_o;
      end else begin : g_lat1
         logic push_q;
         always_ff @(posedge clk) begin
            if (!rst_n) push_q <= 1'b0;
            else        push_q <= rd_en_o;
         end
         assign push_o = push_q;
      end
   endgenerate

endmodule

// File: rtl/bfw_addr_gen.sv
module bfw_addr_gen #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned STEP        = 32,
   parameter int unsigned FRAME_BYTES = 1228800
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              wrap_o
);
   localparam logic [ADDR_W-1:0] STEP_A  = ADDR_W'(STEP);
   localparam logic [ADDR_W-1:0] FRAME_A = ADDR_W'(FRAME_BYTES);

   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] addr_inc;
   logic              at_end;
   logic              wrap_q;

   assign addr_inc = addr_q + STEP_A;
   assign at_end   = (addr_inc == FRAME_A);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         wrap_q <= 1'b0;
      end else begin
         wrap_q <= advance_i & at_end;
         if (advance_i) addr_q <= at_end ? '0 : addr_inc;
      end
   end

   assign addr_o = addr_q;
   assign wrap_o = wrap_q;

endmodule

// File: rtl/burst_frame_writer.sv
module burst_frame_writer #(
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned BURST_LEN = 8,
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned FRAME_W   = 640,
   parameter int unsigned FRAME_H   = 480,
   parameter int unsigned FIFO_LAT  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sensor_ready_i,
   input  logic              memctl_ready_i,
   input  logic              vsync_i,
   input  logic              fifo_prog_empty_i,
   output logic              fifo_rd_en_o,
   input  logic [WORD_W-1:0] fifo_data_i,
   output logic              wr_push_o,
   output logic [WORD_W-1:0] wr_data_o,
   output logic              addr_req_o,
   output logic [ADDR_W-1:0] addr_o,
   input  logic              addr_ack_i,
   output logic              recording_o,
   output logic              frame_done_o
);
   localparam int unsigned WORD_BYTES  = WORD_W / 8;
   localparam int unsigned STEP        = BURST_LEN * WORD_BYTES;
   localparam int unsigned FRAME_BYTES = FRAME_W * FRAME_H * WORD_BYTES;

   generate
      if (WORD_W == 0 || (WORD_W % 8) != 0) begin : g_bad_word
         $error("WORD_W must be a nonzero multiple of 8");
      end
      if (BURST_LEN == 0) begin : g_bad_burst
         $error("BURST_LEN must be at least 1");
      end
      if (FIFO_LAT > 1) begin : g_bad_lat
         $error("FIFO_LAT must be 0 or 1");
      end
      if (FRAME_BYTES == 0 || (FRAME_BYTES % STEP) != 0) begin : g_bad_frame
         $error("frame size must be a whole number of bursts");
      end
      if (ADDR_W < 31 && FRAME_BYTES >= (1 << ADDR_W)) begin : g_bad_addr
         $error("ADDR_W too narrow for one frame");
      end
   endgenerate

   logic active;
   logic advance;

   bfw_run_ctrl run_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .sensor_ready_i (sensor_ready_i),
      .memctl_ready_i (memctl_ready_i),
      .vsync_i        (vsync_i),
      .active_o       (active)
   );

   bfw_burst_fsm #(
      .BURST_LEN (BURST_LEN),
      .FIFO_LAT  (FIFO_LAT)
   ) burst_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .active_i     (active),
      .prog_empty_i (fifo_prog_empty_i),
      .ack_i        (addr_ack_i),
      .rd_en_o      (fifo_rd_en_o),
      .push_o       (wr_push_o),
      .req_o        (addr_req_o),
      .advance_o    (advance)
   );

   bfw_addr_gen #(
      .ADDR_W      (ADDR_W),
      .STEP        (STEP),
      .FRAME_BYTES (FRAME_BYTES)
   ) addr_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .advance_i (advance),
      .addr_o    (addr_o),
      .wrap_o    (frame_done_o)
   );

   assign wr_data_o   = fifo_data_i;
   assign recording_o = active;

endmodule

// File: rtl/bfw_checker.sv
module bfw_checker #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned BURST_LEN   = 8,
   parameter int unsigned STEP        = 32,
   parameter int unsigned FRAME_BYTES = 1228800
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fifo_prog_empty_i,
   input logic              fifo_rd_en_o,
   input logic              wr_push_o,
   input logic              addr_req_o,
   input logic [ADDR_W-1:0] addr_o,
   input logic              addr_ack_i,
   input logic              recording_o,
   input logic              frame_done_o
);
   localparam logic [ADDR_W-1:0] STEP_A  = ADDR_W'(STEP);
   localparam logic [ADDR_W-1:0] FRAME_A = ADDR_W'(FRAME_BYTES);

   int unsigned       push_cnt;
   logic              acc_q;
   logic [ADDR_W-1:0] acc_addr_q;
   logic [ADDR_W-1:0] exp_next;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         push_cnt   <= 0;
         acc_q      <= 1'b0;
         acc_addr_q <= '0;
      end else begin
         acc_q <= addr_req_o & addr_ack_i;
         if (addr_req_o && addr_ack_i) begin
            push_cnt   <= 0;
            acc_addr_q <= addr_o;
         end else if (wr_push_o) begin
            push_cnt <= push_cnt + 1;
         end
      end
   end

   assign exp_next = ((acc_addr_q + STEP_A) == FRAME_A) ? '0 : acc_addr_q + STEP_A;

   AST_IDLE_BEFORE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      !recording_o |-> (!fifo_rd_en_o && !addr_req_o)); // R1
   AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      recording_o |=> recording_o); // R1
   AST_READ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fifo_rd_en_o) |-> $past(!fifo_prog_empty_i)); // R3
   AST_BURST_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(addr_req_o) |-> (push_cnt == BURST_LEN)); // R5
   AST_QUIET_WHILE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      addr_req_o |-> (!fifo_rd_en_o && !wr_push_o)); // R6
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_req_o && !addr_ack_i) |=> (addr_req_o && $stable(addr_o))); // R6
   AST_ADDR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      acc_q |-> (addr_o == exp_next)); // R7
   AST_WRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done_o |-> (acc_q && addr_o == '0)); // R8
   AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      addr_o < FRAME_A); // R8

endmodule

bind burst_frame_writer bfw_checker #(
   .ADDR_W      (ADDR_W),
   .BURST_LEN   (BURST_LEN),
   .STEP        (STEP),
   .FRAME_BYTES (FRAME_BYTES)
) chk_i (
   .clk               (clk),
   .rst_n             (rst_n),
   .fifo_prog_empty_i (fifo_prog_empty_i),
   .fifo_rd_en_o      (fifo_rd_en_o),
   .wr_push_o         (wr_push_o),
   .addr_req_o        (addr_req_o),
   .addr_o            (addr_o),
   .addr_ack_i        (addr_ack_i),
   .recording_o       (recording_o),
   .frame_done_o      (frame_done_o)
);

// File: tb/burst_frame_writer_tb_top.sv
module burst_frame_writer_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int T_BURST    = 8;
   localparam int T_W        = 16;
   localparam int T_H        = 2;
   localparam int T_STEP     = T_BURST * 4;
   localparam int T_FRAME    = T_W * T_H * 4;
   localparam logic [31:0] BASE = 32'hA000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sensor_ready_i = 1'b0;
   logic        memctl_ready_i = 1'b0;
   logic        vsync_i = 1'b0;
   logic        fifo_prog_empty_i;
   logic        fifo_rd_en_o;
   logic [31:0] fifo_data_i;
   logic        wr_push_o;
   logic [31:0] wr_data_o;
   logic        addr_req_o;
   logic [31:0] addr_o;
   logic        addr_ack_i = 1'b0;
   logic        recording_o;
   logic        frame_done_o;

   int n_checks = 0;
   int n_fail   = 0;
   int pix_added = 0;
   int reads_done = 0;
   bit mon_on = 1'b0;
   bit done = 1'b0;

   int pushes = 0, push_since = 0, rd_run = 0;
   int bursts = 0, fd_count = 0, ack_wait = 0, ack_delay = 0;
   int model_addr = 0;
   bit post_acc = 0, wrap_exp = 0, req_prev = 0, push_prev = 0;
   logic [31:0] req_addr = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_frame_writer #(
      .WORD_W (32), .BURST_LEN (T_BURST), .ADDR_W (32),
      .FRAME_W (T_W), .FRAME_H (T_H), .FIFO_LAT (1)
   ) dut_i (
      .clk (clk), .rst_n (rst_n),
      .sensor_ready_i (sensor_ready_i), .memctl_ready_i (memctl_ready_i),
      .vsync_i (vsync_i), .fifo_prog_empty_i (fifo_prog_empty_i),
      .fifo_rd_en_o (fifo_rd_en_o), .fifo_data_i (fifo_data_i),
      .wr_push_o (wr_push_o), .wr_data_o (wr_data_o),
      .addr_req_o (addr_req_o), .addr_o (addr_o), .addr_ack_i (addr_ack_i),
      .recording_o (recording_o), .frame_done_o (frame_done_o)
   );

   // FIFO model: flag from stored count, data is a running sequence
   assign fifo_prog_empty_i = (pix_added - reads_done) < T_BURST;

   always @(posedge clk) begin
      if (!rst_n) begin
         fifo_data_i <= '0;
      end else if (fifo_rd_en_o) begin
         fifo_data_i <= BASE + 32'(reads_done);
         reads_done  <= reads_done + 1;
      end
   end

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (mon_on) begin
         if (post_acc) begin
            check(addr_o == 32'(model_addr), "R7 address after accept", addr_o, model_addr);
            check(frame_done_o == wrap_exp, "R8 wrap pulse", frame_done_o, wrap_exp);
            post_acc = 0;
         end else if (frame_done_o) begin
            check(1'b0, "R8 stray frame_done", 1, 0);
         end
         if (frame_done_o) fd_count++;

         if (fifo_rd_en_o)
            check((pix_added - reads_done) > 0, "R3 read of empty fifo", pix_added - reads_done, 1);
         if (fifo_rd_en_o) rd_run++;
         else if (rd_run != 0) begin
            check(rd_run == T_BURST, "R4 consecutive reads", rd_run, T_BURST);
            rd_run = 0;
         end

         if (wr_push_o) begin
            check(wr_data_o == BASE + 32'(pushes), "R4 push data order", wr_data_o, BASE + 32'(pushes));
            pushes++;
            push_since++;
         end

         if (addr_req_o) begin
            check(!fifo_rd_en_o && !wr_push_o, "R6 quiet while pending", fifo_rd_en_o, 0);
            if (!req_prev) begin
               check(push_since == T_BURST, "R5 pushes before request", push_since, T_BURST);
               check(push_prev, "R5 request follows last push", push_prev, 1);
            end else begin
               check(addr_o == req_addr, "R6 address held", addr_o, req_addr);
            end
            req_addr = addr_o;
         end

         if (addr_ack_i) begin
            addr_ack_i = 1'b0;
         end else if (addr_req_o) begin
            if (ack_wait == ack_delay) begin
               addr_ack_i = 1'b1;
               ack_wait = 0;
               check(addr_o == 32'(model_addr), "R7 request address", addr_o, model_addr);
               wrap_exp = (model_addr + T_STEP == T_FRAME);
               model_addr = wrap_exp ? 0 : model_addr + T_STEP;
               post_acc = 1;
               push_since = 0;
               bursts++;
               ack_delay = (ack_delay + 1) % 4;
            end else begin
               ack_wait++;
            end
         end
         req_prev  = addr_req_o;
         push_prev = wr_push_o;
      end
   end

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      cycles(3);
      // R9: reset state
      check(addr_o == 0, "R9 reset address", addr_o, 0);
      check(!addr_req_o && !fifo_rd_en_o && !wr_push_o, "R9 reset strobes", addr_req_o, 0);
      check(!recording_o && !frame_done_o, "R9 reset status", recording_o, 0);
      rst_n = 1'b1;
      mon_on = 1'b1;
      pix_added = 16;
      // R2: vsync rise before any init is ignored
      vsync_i = 1'b1; cycles(2); vsync_i = 1'b0; cycles(2);
      sensor_ready_i = 1'b1; cycles(2);
      vsync_i = 1'b1; cycles(2); vsync_i = 1'b0; cycles(2);
      check(!recording_o, "R1 one init only", recording_o, 0);
      // R2: vsync already high as init completes
      vsync_i = 1'b1; cycles(2);
      memctl_ready_i = 1'b1; cycles(6);
      check(!recording_o, "R2 held vsync ignored", recording_o, 0);
      check(reads_done == 0, "R1 no reads before start", reads_done, 0);
      vsync_i = 1'b0; cycles(2);
      vsync_i = 1'b1; cycles(1);
      check(recording_o, "R1 start on fresh rise", recording_o, 1);
      vsync_i = 1'b0;
      while (bursts < 2) cycles(1);
      cycles(20);
      check(reads_done == 16, "R3 idle when below threshold", reads_done, 16);
      pix_added += 7; cycles(30);
      check(reads_done == 16 && !addr_req_o, "R3 seven words do not start", reads_done, 16);
      pix_added += 1;
      while (bursts < 3) cycles(1);
      pix_added += 11 * T_BURST;
      while (bursts < 14) cycles(1);
      cycles(6);
      check(fd_count == 3, "R8 wrap count", fd_count, 3);
      check(pushes == 14 * T_BURST, "R4 total pushes", pushes, 14 * T_BURST);
      check(recording_o, "R1 recording stays", recording_o, 1);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", bursts, 14);
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

endmodule